// File: doc/BRIEF.md
# IDE Function Configuration Register File

This block holds the configuration registers of a two-channel IDE storage function. A host-side agent reaches it through a dword-indexed port: one address selects a 32-bit word, a write strobe with four byte enables updates the writable bits of that word, and read data follows the address combinationally. Each register carries its own reset value and a per-bit write mask, so read-only fields keep their reset value whatever is written to them.

Two behaviours set this block apart from a plain register array. First, the low nibble of the programming-interface byte selects legacy mode. While that mode is active, the four command and control base-address words read back as zero, and an unprogrammed bus-master base-address word reads back as a fixed I/O port. The stored base values and the mode flag are also sent out to the channel I/O decoders. Second, one status bit per channel mirrors that channel's interrupt level input, so software can poll the interrupt state through configuration reads.

Top module: `ide_cfg_space`

## Requirements
- R1: After reset, reads return: 0x02800081 at dword 0x01 (I/O enable and wait cycles in the command half; fast back-to-back and medium select timing in the status half), {0x01,0x01,0x8A,REV_ID} at dword 0x02, 0x00000001 at dwords 0x04 to 0x08 (base values before the legacy override), 0xC0 at 0x0D, 0x0E at 0x0F, 0x0A090600/0x00C00068/0xA8A8A8A8/0x000000FF/0x07070707/0x00000004 at 0x10 to 0x15, 0x200 at 0x18 and 0x1A, 0 at 0x1C and 0x1E (with both IRQ inputs low), 0x00020001 at 0x30, and DEV_ID_WORD at 0x00.
- R2: In the programming-interface byte (bits 15:8 of dword 0x02), only bits 8 and 10 (mask 0x05 within the byte) can be written. The other bits always read as in 0x8A. The rest of dword 0x02 is read-only.
- R3: `legacy_mode` is 1 exactly when bits 11:8 of dword 0x02 equal 0xA. A write to that byte changes the flag right after the clock edge that takes the write, and at no other time.
- R4: While legacy mode is set, reads of dwords 0x04 to 0x07 return 0. Outside legacy mode, they return the stored value.
- R5: While legacy mode is set, a read of dword 0x08 whose stored value is 0x00000001 returns 0x0000CC01. Any other stored value, and any read outside legacy mode, returns the stored value.
- R6: The base-address words at dwords 0x04 to 0x08 ignore writes below window sizes of 8, 4, 8, 4 and 16 bytes. Bit 0 always reads 1, and the other bits below the window size read 0.
- R7: Dwords 0x00, 0x0D, 0x0F (interrupt line 0x0E) and 0x30 are read-only.
- R8: Bit 7 of dword 0x1C follows irq_lvl[0], and bit 7 of dword 0x1E follows irq_lvl[1], in the same cycle. Writes to bit 7 are ignored. All other bits of these two dwords are writable.
- R9: A write changes only the bytes whose byte enable is set. Dwords 0x10 to 0x15, 0x18 and 0x1A are fully writable.
- R10: `bar_base` presents the stored values of dwords 0x04 to 0x08, with BAR k at bits 32k+31:32k, whatever the mode.
- R11: In dword 0x01, bits 10:0 are writable and bits 31:11 are read-only.
- R12: Dwords not listed above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 6 | Dword index into the 256-byte space |
| cfg_we | input | 1 | Write strobe, taken at the rising edge |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| irq_lvl | input | 2 | Interrupt level per channel |
| legacy_mode | output | 1 | Legacy-mode flag for the I/O decoders |
| bar_base | output | 160 | Stored base-address words 0 to 4 |

## Verification
The bench switches the programming-interface byte between legacy and native values in the middle of random traffic. A design that latched the mode late, or decoded the wrong nibble, would then return stale or zeroed base-address words. It probes dword 0x08 both unprogrammed and programmed, in both modes, which catches a design that substitutes the fixed port unconditionally or compares the wrong value. Interrupt levels are toggled at random between reads, and writes aimed at bit 7 of the status dwords are mixed in, so a design that stored the level instead of mirroring it, or let the write through, would show the wrong bit. Random byte enables on every word catch masks that leak into hard-wired base bits or into read-only words.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
   localparam int DW        = 32;
   localparam int AW        = 6;
   localparam int NSLOT     = 21;
   localparam int NBAR      = 5;
   localparam int BAR_FIRST = 3;
   localparam int CLASS_SLOT = 2;
   localparam int IRQ_SLOT0 = 18;
   localparam int IRQ_BIT   = 7;

   typedef logic [DW-1:0] dword_t;

   // log2 of the decoded window size of each base-address word
   function automatic int bar_align_log2(int k);
      case (k)
         0: return 3;
         1: return 2;
         2: return 3;
         3: return 2;
         default: return 4;
      endcase
   endfunction

   function automatic logic [AW-1:0] slot_index(int i);
      if (i < BAR_FIRST)            return AW'(i);
      else if (i < BAR_FIRST+NBAR)  return AW'(4 + i - BAR_FIRST);
      else if (i == 8)              return 6'h0D;
      else if (i == 9)              return 6'h0F;
      else if (i < 16)              return AW'(16 + i - 10);
      else if (i == 16)             return 6'h18;
      else if (i == 17)             return 6'h1A;
      else if (i == 18)             return 6'h1C;
      else if (i == 19)             return 6'h1E;
      else                          return 6'h30;
   endfunction

   function automatic dword_t slot_reset(int i, dword_t id_word, logic [7:0] rev);
      case (i)
         0:  return id_word;
         1:  return 32'h0280_0081;
         2:  return {8'h01, 8'h01, 8'h8A, rev};
         3, 4, 5, 6, 7: return 32'h0000_0001;
         8:  return 32'h0000_00C0;
         9:  return 32'h0000_000E;
         10: return 32'h0A09_0600;
         11: return 32'h00C0_0068;
         12: return 32'hA8A8_A8A8;
         13: return 32'h0000_00FF;
         14: return 32'h0707_0707;
         15: return 32'h0000_0004;
         16, 17: return 32'h0000_0200;
         18, 19: return 32'h0000_0000;
         default: return 32'h0002_0001;
      endcase
   endfunction

   function automatic dword_t slot_wmask(int i);
      dword_t lowbits;
      case (i)
         1:  return 32'h0000_07FF;
         2:  return 32'h0000_0500;
         3, 4, 5, 6, 7: begin
            lowbits = (32'h1 << bar_align_log2(i - BAR_FIRST)) - 32'h1;
            return ~lowbits;
         end
         10, 11, 12, 13, 14, 15, 16, 17: return 32'hFFFF_FFFF;
         18, 19: return ~(32'h1 << IRQ_BIT);
         default: return 32'h0000_0000;
      endcase
   endfunction
endpackage

// File: rtl/ide_cfg_word.sv
module ide_cfg_word #(
   parameter int           DW    = 32,
   parameter logic [DW-1:0] RST   = '0,
   parameter logic [DW-1:0] WMASK = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW/8-1:0] be,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   localparam int NB = DW / 8;

   if (DW % 8 != 0) begin : g_bad_width
      $error("ide_cfg_word: DW must be a multiple of 8");
   end

   if (WMASK == '0) begin : g_const
      // read-only word: no storage at all
      logic unused_ins;
      assign unused_ins = ^{clk, rst_n, wr_en, be, wdata};
      assign q = RST;
   end else begin : g_reg
      for (genvar b = 0; b < NB; b++) begin : g_byte
         localparam logic [7:0] M = WMASK[b*8 +: 8];
         localparam logic [7:0] R = RST[b*8 +: 8];
         logic [7:0] byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               byte_q <= R;
            else if (wr_en && be[b])
               byte_q <= (byte_q & ~M) | (wdata[b*8 +: 8] & M);
         end
         assign q[b*8 +: 8] = byte_q;
      end
   end
endmodule

// File: rtl/ide_cfg_rdmux.sv
module ide_cfg_rdmux #(
   parameter int N  = 4,
   parameter int DW = 32
) (
   input  logic [N-1:0]    hit,
   input  logic [N*DW-1:0] vals,
   output logic [DW-1:0]   q
);
   always_comb begin
      q = '0;
      for (int i = 0; i < N; i++)
         q = q | (vals[i*DW +: DW] & {DW{hit[i]}});
   end
endmodule

// File: rtl/ide_cfg_legacy_view.sv
module ide_cfg_legacy_view #(
   parameter int            AW        = 6,
   parameter int            DW        = 32,
   parameter logic [AW-1:0] ZERO_LO   = 6'h04,
   parameter logic [AW-1:0] ZERO_HI   = 6'h07,
   parameter logic [AW-1:0] DFLT_ADDR = 6'h08,
   parameter logic [DW-1:0] UNSET_VAL = 32'h1,
   parameter logic [DW-1:0] DFLT_VAL  = 32'hCC01
) (
   input  logic          legacy,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] raw,
   output logic [DW-1:0] q
);
   logic in_zero;
   assign in_zero = (addr >= ZERO_LO) && (addr <= ZERO_HI);

   always_comb begin
      q = raw;
      if (legacy) begin
         if (in_zero)
            q = '0;
         else if (addr == DFLT_ADDR && raw == UNSET_VAL)
            q = DFLT_VAL;
      end
   end
endmodule

// File: rtl/ide_cfg_space.sv
module ide_cfg_space
   import ide_cfg_pkg::*;
#(
   parameter logic [31:0] DEV_ID_WORD = 32'h5A5A_0F0F,
   parameter logic [7:0]  REV_ID      = 8'h06,
   parameter int          N_CHAN      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [5:0]       cfg_addr,
   input  logic             cfg_we,
   input  logic [3:0]       cfg_be,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   input  logic [1:0]       irq_lvl,
   output logic             legacy_mode,
   output logic [159:0]     bar_base
);
   localparam int NBE = DW / 8;

   if (N_CHAN != 2) begin : g_bad_chan
      $error("ide_cfg_space: exactly two channels are supported");
   end
   if (IRQ_SLOT0 + N_CHAN > NSLOT) begin : g_bad_slots
      $error("ide_cfg_space: interrupt mirror slots exceed table");
   end

   logic [NSLOT-1:0]    hit;
   dword_t              slot_q [NSLOT];
   logic [NSLOT*DW-1:0] vals_flat;
   dword_t              raw_rd;

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      localparam logic [AW-1:0] IDX = slot_index(i);
      assign hit[i] = (cfg_addr == IDX);

      ide_cfg_word #(
         .DW   (DW),
         .RST  (slot_reset(i, DEV_ID_WORD, REV_ID)),
         .WMASK(slot_wmask(i))
      ) u_word (
         .clk  (clk),
         .rst_n(rst_n),
         .wr_en(cfg_we && hit[i]),
         .be   (cfg_be[NBE-1:0]),
         .wdata(cfg_wdata),
         .q    (slot_q[i])
      );

      if (i >= IRQ_SLOT0 && i < IRQ_SLOT0 + N_CHAN) begin : g_irq
         assign vals_flat[i*DW +: DW] =
            slot_q[i] | (DW'(irq_lvl[i - IRQ_SLOT0]) << IRQ_BIT);
      end else begin : g_plain
         assign vals_flat[i*DW +: DW] = slot_q[i];
      end
   end

   for (genvar k = 0; k < NBAR; k++) begin : g_bar_out
      assign bar_base[k*DW +: DW] = slot_q[BAR_FIRST + k];
   end

   assign legacy_mode = (slot_q[CLASS_SLOT][11:8] == 4'hA);

   ide_cfg_rdmux #(.N(NSLOT), .DW(DW)) u_rdmux (
      .hit (hit),
      .vals(vals_flat),
      .q   (raw_rd)
   );

   ide_cfg_legacy_view #(
      .AW       (AW),
      .DW       (DW),
      .ZERO_LO  (slot_index(BAR_FIRST)),
      .ZERO_HI  (slot_index(BAR_FIRST + 3)),
      .DFLT_ADDR(slot_index(BAR_FIRST + 4)),
      .UNSET_VAL(32'h0000_0001),
      .DFLT_VAL (32'h0000_CC01)
   ) u_view (
      .legacy(legacy_mode),
      .addr  (cfg_addr),
      .raw   (raw_rd),
      .q     (cfg_rdata)
   );
endmodule

// File: rtl/ide_cfg_space_chk.sv
module ide_cfg_space_chk (
   input logic         clk,
   input logic         rst_n,
   input logic [5:0]   cfg_addr,
   input logic         cfg_we,
   input logic [3:0]   cfg_be,
   input logic [31:0]  cfg_rdata,
   input logic [1:0]   irq_lvl,
   input logic         legacy_mode,
   input logic [159:0] bar_base
);
   p_irq0_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == 6'h1C) |-> (cfg_rdata[7] == irq_lvl[0]));

   p_irq1_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == 6'h1E) |-> (cfg_rdata[7] == irq_lvl[1]));

   p_bar_hidden_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_mode && cfg_addr >= 6'h04 && cfg_addr <= 6'h07) |-> (cfg_rdata == 32'h0));

   p_progif_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == 6'h02) |-> ((cfg_rdata[15:8] & 8'hFA) == 8'h8A));

   p_intline_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == 6'h0F) |-> (cfg_rdata == 32'h0000_000E));

   p_bar_lowbits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_base[2:0] == 3'b001) && (bar_base[33:32] == 2'b01) &&
      (bar_base[66:64] == 3'b001) && (bar_base[97:96] == 2'b01) &&
      (bar_base[131:128] == 4'b0001));

   p_mode_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(legacy_mode) |-> $past(cfg_we && cfg_addr == 6'h02 && cfg_be[1]));
endmodule

bind ide_cfg_space ide_cfg_space_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_addr   (cfg_addr),
   .cfg_we     (cfg_we),
   .cfg_be     (cfg_be),
   .cfg_rdata  (cfg_rdata),
   .irq_lvl    (irq_lvl),
   .legacy_mode(legacy_mode),
   .bar_base   (bar_base)
);

// File: tb/sim_ide_cfg_space.sv
`timescale 1ns/1ps
module sim_ide_cfg_space;
   localparam logic [31:0] ID_W = 32'h1B2C_3D4E;
   localparam logic [7:0]  REV  = 8'h06;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [5:0]   cfg_addr = '0;
   logic         cfg_we = 1'b0;
   logic [3:0]   cfg_be = '0;
   logic [31:0]  cfg_wdata = '0;
   logic [31:0]  cfg_rdata;
   logic [1:0]   irq_lvl = '0;
   logic         legacy_mode;
   logic [159:0] bar_base;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   logic [31:0] mem [64];

   always #4 clk = ~clk;

   ide_cfg_space #(.DEV_ID_WORD(ID_W), .REV_ID(REV), .N_CHAN(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .irq_lvl(irq_lvl), .legacy_mode(legacy_mode), .bar_base(bar_base)
   );

   // expected reset values (R1)
   function automatic logic [31:0] exp_rst(int a);
      case (a)
         8'h00: return ID_W;
         8'h01: return 32'h0280_0081;
         8'h02: return {8'h01, 8'h01, 8'h8A, REV};
         8'h04, 8'h05, 8'h06, 8'h07, 8'h08: return 32'h1;
         8'h0D: return 32'hC0;
         8'h0F: return 32'h0E;
         8'h10: return 32'h0A09_0600;
         8'h11: return 32'h00C0_0068;
         8'h12: return 32'hA8A8_A8A8;
         8'h13: return 32'h0000_00FF;
         8'h14: return 32'h0707_0707;
         8'h15: return 32'h0000_0004;
         8'h18, 8'h1A: return 32'h200;
         8'h30: return 32'h0002_0001;
         default: return 32'h0;
      endcase
   endfunction

   // writable bits per requirement R2, R6, R8, R9, R11
   function automatic logic [31:0] exp_msk(int a);
      case (a)
         8'h01: return 32'h0000_07FF;
         8'h02: return 32'h0000_0500;
         8'h04, 8'h06: return 32'hFFFF_FFF8;
         8'h05, 8'h07: return 32'hFFFF_FFFC;
         8'h08: return 32'hFFFF_FFF0;
         8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h18, 8'h1A: return 32'hFFFF_FFFF;
         8'h1C, 8'h1E: return 32'hFFFF_FF7F;
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit exp_legacy();
      return mem[2][11:8] == 4'hA;
   endfunction

   function automatic logic [31:0] exp_read(int a);
      logic [31:0] v;
      v = mem[a];
      if (a == 8'h1C) v[7] = irq_lvl[0];
      if (a == 8'h1E) v[7] = irq_lvl[1];
      if (exp_legacy()) begin
         if (a >= 4 && a <= 7) v = 32'h0;
         else if (a == 8 && v == 32'h1) v = 32'h0000_CC01;
      end
      return v;
   endfunction

   function automatic string tag_of(int a);
      if (a >= 4 && a <= 7) return exp_legacy() ? "R4" : "R6";
      if (a == 8) return (exp_legacy() && mem[8] == 32'h1) ? "R5" : "R6";
      if (a == 1) return "R11";
      if (a == 2) return "R2";
      if (a == 0 || a == 8'h0D || a == 8'h0F || a == 8'h30) return "R7";
      if (a >= 8'h10 && a <= 8'h1A) return "R9";
      if (a == 8'h1C || a == 8'h1E) return "R8";
      return "R12";
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_write(int a, logic [3:0] be, logic [31:0] d);
      logic [31:0] m;
      @(negedge clk);
      cfg_addr = 6'(a); cfg_be = be; cfg_wdata = d; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      m = exp_msk(a);
      for (int b = 0; b < 4; b++)
         if (be[b]) begin
            mem[a][b*8 +: 8] = (mem[a][b*8 +: 8] & ~m[b*8 +: 8]) | (d[b*8 +: 8] & m[b*8 +: 8]);
         end
   endtask

   task automatic do_read(int a, string tag);
      @(negedge clk);
      cfg_addr = 6'(a); cfg_we = 1'b0;
      #1;
      check(tag, cfg_rdata, exp_read(a));
   endtask

   task automatic check_outputs(string tag);
      #1;
      check(tag, {31'h0, legacy_mode}, {31'h0, exp_legacy()});
      for (int k = 0; k < 5; k++)
         check("R10", bar_base[k*32 +: 32], mem[4 + k]);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int seed;
      int a;
      logic [31:0] r;
      seed = $urandom(32'd7781);
      for (int i = 0; i < 64; i++) mem[i] = exp_rst(i);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state (read raw words outside legacy windows, legacy view for BARs)
      for (int i = 0; i < 64; i++) begin
         @(negedge clk); cfg_addr = 6'(i); #1;
         check((i >= 4 && i <= 8) ? tag_of(i) : "R1", cfg_rdata, exp_read(i));
      end
      check_outputs("R3");

      // R5 unprogrammed BAR4 in legacy mode shows fixed port
      do_read(8, "R5");
      // R4 write BAR0 in legacy: reads zero, output shows stored (R10)
      do_write(4, 4'hF, 32'h0000_01F5);
      do_read(4, "R4");
      check_outputs("R3");
      // R3 leave legacy: progif 0x8F
      do_write(2, 4'h2, 32'h0000_FF00);
      check_outputs("R3");
      do_read(4, "R6");
      do_read(8, "R6");
      do_read(2, "R2");
      // R3 back to legacy, BAR4 programmed: stored value returned (R5)
      do_write(8, 4'h1, 32'h0000_00A1);
      do_write(2, 4'h2, 32'h0000_0000);
      check_outputs("R3");
      do_read(8, "R5");
      do_write(8, 4'hF, 32'h0000_0001);
      do_read(8, "R5");
      // R8 irq mirror and write to bit 7 ignored
      do_write(8'h1C, 4'h1, 32'h0000_00FF);
      do_read(8'h1C, "R8");
      @(negedge clk) irq_lvl = 2'b01;
      do_read(8'h1C, "R8");
      @(negedge clk) irq_lvl = 2'b10;
      do_read(8'h1C, "R8");
      do_read(8'h1E, "R8");
      @(negedge clk) irq_lvl = 2'b00;
      do_read(8'h1E, "R8");
      // R7 read-only words
      do_write(8'h0F, 4'hF, 32'hFFFF_FFFF);
      do_read(8'h0F, "R7");
      do_write(8'h30, 4'hF, 32'h0);
      do_read(8'h30, "R7");
      // R12 unimplemented
      do_write(8'h3F, 4'hF, 32'hDEAD_BEEF);
      do_read(8'h3F, "R12");
      // R9 partial byte enable
      do_write(8'h12, 4'b0101, 32'h1122_3344);
      do_read(8'h12, "R9");
      // R11 command/status
      do_write(1, 4'hF, 32'hFFFF_FFFF);
      do_read(1, "R11");

      // constrained random traffic
      for (int it = 0; it < 600; it++) begin
         r = $urandom;
         case (r[2:0])
            3'd0: a = 2;
            3'd1, 3'd2: a = 4 + int'(r[5:3] % 3'd5);
            3'd3: a = (r[6]) ? 8'h1C : 8'h1E;
            default: a = int'($urandom % 64);
         endcase
         if (r[9:7] == 3'd0) begin
            @(negedge clk) irq_lvl = 2'($urandom);
         end
         if (a == 2 && r[10]) do_write(2, 4'hF, {16'h0, 3'b0, r[11], 1'b0, r[12], 8'h00} | 32'h0000_0A00);
         else do_write(a, 4'($urandom), $urandom);
         do_read(a, tag_of(a));
         if (r[15:13] == 3'd0) check_outputs("R3");
      end

      // final sweep
      for (int i = 0; i < 64; i++) do_read(i, tag_of(i));
      finish_run();
   end
endmodule